// File: doc/BRIEF.md
# Deblocking Edge Strength Unit

This unit grades one 4x4 block edge for a video deblocking filter. Each cycle it may accept the side information of the two blocks that meet at the edge: intra flags, coded-coefficient flags, reference indices, reference counts and motion vectors. It returns a strength from 0 to 4 one clock later, with a valid strobe. The pixel filter downstream reads this value to choose its filter mode, or to skip the edge when the value is 0.

Luma edges go through a strict priority ladder. Intra coding comes first, and it is split by whether the edge lies on a macroblock boundary. Coded coefficients come next, then motion and reference mismatch. The unit keeps the final luma result for every edge position and direction. A chroma edge does not evaluate its own side information. It returns the stored strength of the luma edge at the same position. Edges on the picture border, and edges whose filtering is switched off, always give strength 0.

Top module: `dbk_bs_calc`

## Requirements
- R1: A luma edge with `mb_edge`=1 where either block has its intra flag set gives strength 4.
- R2: A luma edge with `mb_edge`=0 where either block has its intra flag set gives strength 3. This holds even when coefficient or motion conditions are also true.
- R3: A luma edge where neither block is intra and at least one coefficient flag is set gives strength 2.
- R4: Without intra or coefficients, the strength is 1 when the reference indices differ or the reference counts differ.
- R5: Without intra or coefficients, the strength is 1 when the horizontal or vertical motion components (signed, quarter-sample units) differ in magnitude by 4 or more. A difference of 3 or less, with matching references, gives 0.
- R6: A luma edge that meets none of the conditions in R1 to R5 gives strength 0.
- R7: When `pic_edge`=1 or `filt_off`=1, the output is 0 for both luma and chroma. This forced 0 is also the value stored for that luma edge.
- R8: A chroma edge (`is_chroma`=1) returns the last stored luma strength for the same {`edge_vert`, `edge_pos`}, unless R7 forces it to 0. Its own intra, coefficient, reference and motion inputs have no effect. Vertical and horizontal edges at the same position are stored separately. Stored values are 0 after reset.
- R9: `out_valid` is high exactly in the cycle after an accepted `in_valid` and low otherwise. `out_bs` holds the strength for that input. After reset, `out_valid`=0 and `out_bs`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Edge descriptor present this cycle |
| p_intra | input | 1 | Block p is intra coded |
| q_intra | input | 1 | Block q is intra coded |
| p_coef | input | 1 | Block p has nonzero coefficients |
| q_coef | input | 1 | Block q has nonzero coefficients |
| p_ref | input | REF_W | Reference index of p |
| q_ref | input | REF_W | Reference index of q |
| p_nref | input | CNT_W | Reference count of p |
| q_nref | input | CNT_W | Reference count of q |
| p_mvx | input | MV_W | Horizontal motion of p, signed |
| p_mvy | input | MV_W | Vertical motion of p, signed |
| q_mvx | input | MV_W | Horizontal motion of q, signed |
| q_mvy | input | MV_W | Vertical motion of q, signed |
| mb_edge | input | 1 | Edge lies on a macroblock boundary |
| edge_vert | input | 1 | 1 = vertical edge, 0 = horizontal edge |
| edge_pos | input | POS_W | Edge position inside the macroblock |
| pic_edge | input | 1 | Edge lies on the picture border |
| filt_off | input | 1 | Filtering disabled for this edge |
| is_chroma | input | 1 | Edge belongs to a chroma plane |
| out_valid | output | 1 | Strength valid |
| out_bs | output | 3 | Boundary strength 0..4 |

## Verification
The hardest behaviour to reach from the ports is chroma reuse. Its result depends on which luma edges were seen earlier and in which direction, not on the inputs in the same cycle. The stimulus first writes different luma strengths to a vertical edge and a horizontal edge at the same position. It then sends chroma descriptors whose own side information points to a different answer, so only the stored value can match. The motion threshold is approached from both sides with negative and mixed-sign vectors, including a difference of exactly 3 and exactly 4.

// File: rtl/dbk_bs_pkg.sv
package dbk_bs_pkg;
  typedef enum logic [2:0] {
    BS_NONE     = 3'd0,
    BS_MOTION   = 3'd1,
    BS_COEF     = 3'd2,
    BS_INTRA_IN = 3'd3,
    BS_INTRA_MB = 3'd4
  } bs_e;

  localparam int BS_W = 3;
  localparam int N_COMP = 2;
endpackage

// File: rtl/dbk_mv_cmp.sv
module dbk_mv_cmp #(
  parameter int MV_W = 14,
  parameter int THR  = 4
) (
  input  logic [dbk_bs_pkg::N_COMP*MV_W-1:0] p_mv,
  input  logic [dbk_bs_pkg::N_COMP*MV_W-1:0] q_mv,
  output logic                               differ
);
  localparam int NC = dbk_bs_pkg::N_COMP;
  localparam int DW = MV_W + 1;

  logic [NC-1:0] far;

  genvar c;
  generate
    for (c = 0; c < NC; c++) begin : g_comp
      logic signed [DW-1:0] dlt;
      logic        [DW-1:0] mag;
      always_comb begin
        dlt = $signed({p_mv[c*MV_W+MV_W-1], p_mv[c*MV_W +: MV_W]})
            - $signed({q_mv[c*MV_W+MV_W-1], q_mv[c*MV_W +: MV_W]});
        mag = dlt[DW-1] ? DW'(-dlt) : DW'(dlt);
        far[c] = (mag >= DW'(THR));
      end
    end
  endgenerate

  assign differ = |far;
endmodule

// File: rtl/dbk_bs_decide.sv
module dbk_bs_decide
  import dbk_bs_pkg::*;
(
  input  logic intra_any,
  input  logic mb_edge,
  input  logic coef_any,
  input  logic ref_mismatch,
  input  logic mv_far,
  output bs_e  bs
);
  always_comb begin
    if (intra_any)
      bs = mb_edge ? BS_INTRA_MB : BS_INTRA_IN;
    else if (coef_any)
      bs = BS_COEF;
    else if (ref_mismatch || mv_far)
      bs = BS_MOTION;
    else
      bs = BS_NONE;
  end
endmodule

// File: rtl/dbk_bs_store.sv
module dbk_bs_store #(
  parameter int POS_W = 4,
  parameter int BS_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [POS_W:0]   wr_idx,
  input  logic [BS_W-1:0]  wr_bs,
  input  logic [POS_W:0]   rd_idx,
  output logic [BS_W-1:0]  rd_bs
);
  localparam int DEPTH = 2 ** (POS_W + 1);

  logic [BS_W-1:0] tab [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) tab[i] <= '0;
    end else if (wr_en) begin
      tab[wr_idx] <= wr_bs;
    end
  end

  assign rd_bs = tab[rd_idx];
endmodule

// File: rtl/dbk_bs_calc.sv
module dbk_bs_calc
  import dbk_bs_pkg::*;
#(
  parameter int REF_W  = 4,
  parameter int CNT_W  = 2,
  parameter int MV_W   = 14,
  parameter int POS_W  = 4,
  parameter int MV_THR = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             p_intra,
  input  logic             q_intra,
  input  logic             p_coef,
  input  logic             q_coef,
  input  logic [REF_W-1:0] p_ref,
  input  logic [REF_W-1:0] q_ref,
  input  logic [CNT_W-1:0] p_nref,
  input  logic [CNT_W-1:0] q_nref,
  input  logic [MV_W-1:0]  p_mvx,
  input  logic [MV_W-1:0]  p_mvy,
  input  logic [MV_W-1:0]  q_mvx,
  input  logic [MV_W-1:0]  q_mvy,
  input  logic             mb_edge,
  input  logic             edge_vert,
  input  logic [POS_W-1:0] edge_pos,
  input  logic             pic_edge,
  input  logic             filt_off,
  input  logic             is_chroma,
  output logic             out_valid,
  output logic [2:0]       out_bs
);
  logic            mv_far;
  bs_e             luma_bs;
  logic [BS_W-1:0] luma_final;
  logic [BS_W-1:0] stored_bs;
  logic [BS_W-1:0] next_bs;
  logic [POS_W:0]  idx;
  logic            suppress;

  assign idx      = {edge_vert, edge_pos};
  assign suppress = pic_edge | filt_off;

  dbk_mv_cmp #(.MV_W(MV_W), .THR(MV_THR)) u_mv (
    .p_mv   ({p_mvy, p_mvx}),
    .q_mv   ({q_mvy, q_mvx}),
    .differ (mv_far)
  );

  dbk_bs_decide u_dec (
    .intra_any    (p_intra | q_intra),
    .mb_edge      (mb_edge),
    .coef_any     (p_coef | q_coef),
    .ref_mismatch ((p_ref != q_ref) || (p_nref != q_nref)),
    .mv_far       (mv_far),
    .bs           (luma_bs)
  );

  assign luma_final = suppress ? BS_W'(BS_NONE) : BS_W'(luma_bs);

  dbk_bs_store #(.POS_W(POS_W), .BS_W(BS_W)) u_store (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (in_valid & ~is_chroma),
    .wr_idx (idx),
    .wr_bs  (luma_final),
    .rd_idx (idx),
    .rd_bs  (stored_bs)
  );

  assign next_bs = is_chroma ? (suppress ? '0 : stored_bs) : luma_final;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_bs    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_bs <= next_bs;
    end
  end

  // Strength grading checks
  assert_intra_mb_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid && !is_chroma && !suppress && (p_intra || q_intra) && mb_edge
    |=> out_bs == 3'd4);

  assert_intra_inner_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid && !is_chroma && !suppress && (p_intra || q_intra) && !mb_edge
    |=> out_bs == 3'd3);

  assert_coef_R3: assert property (@(posedge clk) disable iff (rst)
    in_valid && !is_chroma && !suppress && !p_intra && !q_intra && (p_coef || q_coef)
    |=> out_bs == 3'd2);

  assert_ref_R4: assert property (@(posedge clk) disable iff (rst)
    in_valid && !is_chroma && !suppress && !p_intra && !q_intra && !p_coef && !q_coef
    && (p_ref != q_ref)
    |=> out_bs == 3'd1);

  assert_same_motion_R6: assert property (@(posedge clk) disable iff (rst)
    in_valid && !is_chroma && !p_intra && !q_intra && !p_coef && !q_coef
    && p_ref == q_ref && p_nref == q_nref && p_mvx == q_mvx && p_mvy == q_mvy
    |=> out_bs == 3'd0);

  assert_force_zero_R7: assert property (@(posedge clk) disable iff (rst)
    in_valid && suppress |=> out_bs == 3'd0);

  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_valid_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_range_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_bs <= 3'd4);
endmodule

// File: tb/dbk_bs_calc_tb.sv
module dbk_bs_calc_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic p_intra = 0, q_intra = 0, p_coef = 0, q_coef = 0;
  logic [3:0] p_ref = 0, q_ref = 0;
  logic [1:0] p_nref = 0, q_nref = 0;
  logic [13:0] p_mvx = 0, p_mvy = 0, q_mvx = 0, q_mvy = 0;
  logic mb_edge = 0, edge_vert = 0, pic_edge = 0, filt_off = 0, is_chroma = 0;
  logic [3:0] edge_pos = 0;
  logic out_valid;
  logic [2:0] out_bs;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0, mon_on = 0;
  int exp_q[$];
  int cyc_q[$];
  string tag_q[$];
  int mtab[32];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dbk_bs_calc u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .p_intra(p_intra), .q_intra(q_intra), .p_coef(p_coef), .q_coef(q_coef),
    .p_ref(p_ref), .q_ref(q_ref), .p_nref(p_nref), .q_nref(q_nref),
    .p_mvx(p_mvx), .p_mvy(p_mvy), .q_mvx(q_mvx), .q_mvy(q_mvy),
    .mb_edge(mb_edge), .edge_vert(edge_vert), .edge_pos(edge_pos),
    .pic_edge(pic_edge), .filt_off(filt_off), .is_chroma(is_chroma),
    .out_valid(out_valid), .out_bs(out_bs)
  );

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic send(input bit pi, qi, pc, qc, input int pr, qr, pn, qn,
                      input int pmx, pmy, qmx, qmy, input bit mb, vt,
                      input int pos, input bit pic, off, chr, input string tag);
    int e;
    int ix;
    @(negedge clk);
    in_valid = 1; p_intra = pi; q_intra = qi; p_coef = pc; q_coef = qc;
    p_ref = pr[3:0]; q_ref = qr[3:0]; p_nref = pn[1:0]; q_nref = qn[1:0];
    p_mvx = pmx[13:0]; p_mvy = pmy[13:0]; q_mvx = qmx[13:0]; q_mvy = qmy[13:0];
    mb_edge = mb; edge_vert = vt; edge_pos = pos[3:0];
    pic_edge = pic; filt_off = off; is_chroma = chr;
    ix = (vt ? 16 : 0) + pos;
    if (chr) e = mtab[ix];
    else if (pi || qi) e = mb ? 4 : 3;
    else if (pc || qc) e = 2;
    else if (pr != qr || pn != qn || iabs(pmx - qmx) >= 4 || iabs(pmy - qmy) >= 4) e = 1;
    else e = 0;
    if (pic || off) e = 0;
    if (!chr) mtab[ix] = e;
    exp_q.push_back(e);
    cyc_q.push_back(cyc + 1);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0;
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (mon_on && out_valid) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R9: out_valid high with nothing pending, actual bs=%0d expected none", out_bs);
      end else begin
        int e, c;
        string t;
        e = exp_q.pop_front();
        c = cyc_q.pop_front();
        t = tag_q.pop_front();
        if (int'(out_bs) != e || cyc != c) begin
          n_bad++;
          $display("FAIL %s: actual bs=%0d at cycle %0d, expected bs=%0d at cycle %0d",
                   t, out_bs, cyc, e, c);
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) mtab[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0 || out_bs !== 3'd0) begin
      n_bad++;
      $display("FAIL R9: reset state actual valid=%0b bs=%0d, expected 0/0", out_valid, out_bs);
    end
    mon_on = 1;

    // R8: chroma before any luma reads reset value 0
    send(1,1,1,1, 1,2,0,1, 0,0,40,40, 1,1,5, 0,0,1, "R8");
    // R1
    send(1,0,0,0, 0,0,0,0, 0,0,0,0, 1,1,0, 0,0,0, "R1");
    send(0,1,0,0, 0,0,0,0, 0,0,0,0, 1,0,0, 0,0,0, "R1");
    // R2
    send(1,0,1,1, 3,4,0,1, 0,0,99,0, 0,1,1, 0,0,0, "R2");
    send(0,1,0,0, 0,0,0,0, 0,0,0,0, 0,0,2, 0,0,0, "R2");
    // R3
    send(0,0,1,0, 0,0,0,0, 0,0,0,0, 0,1,3, 0,0,0, "R3");
    send(0,0,0,1, 2,5,0,0, 8,0,-8,0, 1,0,3, 0,0,0, "R3");
    // R4
    send(0,0,0,0, 1,2,0,0, 0,0,0,0, 0,1,4, 0,0,0, "R4");
    send(0,0,0,0, 3,3,1,2, 0,0,0,0, 0,0,4, 0,0,0, "R4");
    idle(2);
    // R5 threshold boundaries
    send(0,0,0,0, 0,0,0,0, 4,0,0,0, 0,1,6, 0,0,0, "R5");
    send(0,0,0,0, 0,0,0,0, 0,-2,0,2, 0,1,7, 0,0,0, "R5");
    send(0,0,0,0, 0,0,0,0, -3,0,0,0, 0,1,8, 0,0,0, "R5");
    send(0,0,0,0, 0,0,0,0, -1,-100,2,-97, 0,1,9, 0,0,0, "R5");
    send(0,0,0,0, 0,0,0,0, -8192,0,-8188,0, 0,0,6, 0,0,0, "R5");
    send(0,0,0,0, 0,0,0,0, 8191,0,-8192,0, 0,0,7, 0,0,0, "R5");
    // R6
    send(0,0,0,0, 2,2,1,1, 17,-5,17,-5, 1,0,8, 0,0,0, "R6");
    // R7
    send(1,1,1,1, 0,0,0,0, 0,0,0,0, 1,1,10, 1,0,0, "R7");
    send(1,0,0,0, 0,0,0,0, 0,0,0,0, 1,0,10, 0,1,0, "R7");
    // R8: set distinct strengths per direction at position 12
    send(1,0,0,0, 0,0,0,0, 0,0,0,0, 1,1,12, 0,0,0, "R8");
    send(0,0,0,0, 1,0,0,0, 0,0,0,0, 0,0,12, 0,0,0, "R8");
    send(0,0,0,0, 0,0,0,0, 0,0,0,0, 0,1,12, 0,0,1, "R8");
    send(1,1,1,1, 0,0,0,0, 0,0,0,0, 1,0,12, 0,0,1, "R8");
    send(0,0,0,0, 0,0,0,0, 0,0,0,0, 0,1,2, 0,0,1, "R8");
    send(0,0,0,0, 0,0,0,0, 0,0,0,0, 0,1,10, 0,0,1, "R8");
    // R7 on chroma whose stored luma is 4
    send(0,0,0,0, 0,0,0,0, 0,0,0,0, 0,1,12, 0,1,1, "R7");
    // R8: overwrite luma then re-read
    send(0,0,1,0, 0,0,0,0, 0,0,0,0, 0,1,12, 0,0,0, "R8");
    send(0,0,0,0, 0,0,0,0, 0,0,0,0, 0,1,12, 0,0,1, "R8");
    idle(3);
    // R9: longer back-to-back burst sweeping positions
    for (int k = 0; k < 16; k++)
      send(0,0,k[0],0, k%3,0,0,0, k,0,0,0, k[1],k[2],k, 0,0,0, "R9");
    for (int k = 0; k < 16; k++)
      send(0,0,0,0, 0,0,0,0, 0,0,0,0, 0,k[2],k, 0,0,1, "R8");
    idle(4);

    n_chk++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R9: %0d results missing, expected 0", exp_q.size());
    end
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL R9: watchdog expired, actual hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule